// File: doc/BRIEF.md
# Analog Pin Boundary Control Cell

This block is the digital control slice that sits beside one analog pin in a mixed-signal boundary-scan chain. A serial stage is loaded one bit per test clock through the scan path. A parallel stage then holds the control word while the next word is shifted in. The held word, gated by the test instruction the TAP decoder currently selects, is turned into a set of switch enables. These enables decide whether the pin stays joined to the core, whether it is forced to a high, low or reference level, and whether it is tied to the stimulus-current bus or to the voltage-monitor bus.

For sensing, a comparator outside this block compares the pin voltage with a threshold. Its one-bit result is loaded into the serial stage during capture, so the tester can shift it out together with a readback of the held control word. The TAP controller, the analog switches and the comparator are not part of the block. Each state strobe and each switch is a plain signal.

Top module: `abm_control_cell`

## Requirements
- R1: A synchronous reset (rst_n low at a rising tck edge) clears both stages. After that edge, sw_core is 1, all drive and bus enables are 0, and scan_out is 0, whatever the value of test_instr.
- R2: In a cycle with capture_dr high, stage bit 0 loads comp_out and bits 6..1 load the held control bits. scan_out shows stage bit 0 after the edge.
- R3: In a cycle with shift_dr high and capture_dr low, each stage bit takes the value of the next higher bit and bit 6 takes scan_in. scan_out is therefore stage bit 0, and a bit shifted in appears on scan_out seven edges later.
- R4: The held control bits (stage bits 6..1) change only on an edge where update_dr is high. While update_dr is low the switch enables do not change unless test_instr changes.
- R5: While test_instr is 0, sw_core is 1 and every drive and bus enable is 0, whatever the held bits are.
- R6: While test_instr is 1, sw_core is the inverse of the disconnect bit (held bit 1).
- R7: While test_instr is 1 and both the disconnect bit and the drive-enable bit (bit 2) are 1, the level field {bit4,bit3} selects the drive: 00 enables sw_vl, 01 enables sw_vh, 10 enables sw_vref, 11 enables no drive. At most one drive enable is ever active.
- R8: No drive enable is active while sw_core is 1. A set drive-enable bit with the disconnect bit at 0 drives nothing.
- R9: While test_instr is 1, sw_bus_stim follows held bit 5 and sw_bus_mon follows held bit 6, whatever the disconnect bit is.
- R10: When capture_dr and shift_dr are both high, capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low test reset |
| test_instr | input | 1 | A test instruction that uses this cell is active |
| capture_dr | input | 1 | Capture-DR state strobe |
| shift_dr | input | 1 | Shift-DR state strobe |
| update_dr | input | 1 | Update-DR state strobe |
| scan_in | input | 1 | Serial data from the previous cell |
| comp_out | input | 1 | Comparator result (pin above threshold) |
| scan_out | output | 1 | Serial data to the next cell |
| sw_core | output | 1 | Pin-to-core switch enable |
| sw_vh | output | 1 | Drive to high level |
| sw_vl | output | 1 | Drive to low level |
| sw_vref | output | 1 | Drive to reference ground |
| sw_bus_stim | output | 1 | Join pin to stimulus-current bus |
| sw_bus_mon | output | 1 | Join pin to voltage-monitor bus |

## Verification
Directed words walk all four level codes with the disconnect and drive-enable bits set, which separates the three drive enables from each other and from the "no drive" code. Words with drive enabled and disconnect cleared, and every word again with the instruction low, show that core connection wins over any drive. Random words, instruction values and comparator bits are loaded and read back by capture-and-shift. This tells a wrong bit order or a lost bit in the serial stage apart from a wrong decode. During each shift the switch enables are watched so that a leak from the serial stage into the held stage is caught.

// File: rtl/abm_pkg.sv
// Package: shared field positions and types for the analog pin control cell.
// Assumes: the serial stage is seven bits, bit 0 nearest scan_out.
package abm_pkg;
    localparam int CHAIN_LEN = 7;
    localparam int SENSE_BIT = 0;
    localparam int DISC_BIT  = 1;
    localparam int DREN_BIT  = 2;
    localparam int LVL_LSB   = 3;
    localparam int LVL_W     = 2;
    localparam int STIM_BIT  = 5;
    localparam int MON_BIT   = 6;
    localparam int CTRL_W    = CHAIN_LEN - 1;

    typedef enum logic [LVL_W-1:0] {
        LVL_LOW  = 2'd0,
        LVL_HIGH = 2'd1,
        LVL_REF  = 2'd2,
        LVL_NONE = 2'd3
    } drive_lvl_e;

    typedef struct packed {
        logic core;
        logic vh;
        logic vl;
        logic vref;
        logic stim;
        logic mon;
    } sw_en_t;
endpackage

// File: rtl/abm_shift_stage.sv
// Module: serial scan stage. It captures the comparator bit and the held word,
// and it shifts toward bit 0. Assumes: capture has priority over shift.
module abm_shift_stage #(
    parameter int LEN = abm_pkg::CHAIN_LEN
) (
    input  logic           tck,
    input  logic           rst_n,
    input  logic           capture_en,
    input  logic           shift_en,
    input  logic           scan_in,
    input  logic           sense_bit,
    input  logic [LEN-1:1] held_bits,
    output logic           scan_out,
    output logic [LEN-1:1] par_out
);
    logic [LEN-1:0] sr_q;
    logic [LEN-1:0] cap_vec;
    logic [LEN-1:0] shf_vec;

    assign cap_vec = {held_bits, sense_bit};

    genvar gi;
    generate
        for (gi = 0; gi < LEN; gi++) begin : g_bit
            if (gi == LEN - 1) begin : g_top
                assign shf_vec[gi] = scan_in;
            end else begin : g_mid
                assign shf_vec[gi] = sr_q[gi+1];
            end
            // Per-bit register: reset, capture, shift or hold.
            always_ff @(posedge tck) begin
                if (!rst_n)          sr_q[gi] <= 1'b0;
                else if (capture_en) sr_q[gi] <= cap_vec[gi];
                else if (shift_en)   sr_q[gi] <= shf_vec[gi];
            end
        end
    endgenerate

    assign scan_out = sr_q[0];
    assign par_out  = sr_q[LEN-1:1];
endmodule

// File: rtl/abm_update_stage.sv
// Module: parallel hold stage, loaded only on the update strobe.
// Assumes: reset leaves every control bit at 0 (the core-connected, undriven state).
module abm_update_stage #(
    parameter int W = abm_pkg::CTRL_W
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Holding register for the control word.
    always_ff @(posedge tck) begin
        if (!rst_n)       q <= '0;
        else if (load_en) q <= d;
    end
endmodule

// File: rtl/abm_switch_decode.sv
// Module: turns the held control bits and the instruction gate into switch enables.
// Assumes: ctrl bit k holds stage bit k+1 (disconnect is ctrl[0]).
module abm_switch_decode
    import abm_pkg::*;
(
    input  logic              test_instr,
    input  logic [CTRL_W-1:0] ctrl,
    output sw_en_t            sw
);
    logic       disc;
    logic       drive_ok;
    drive_lvl_e lvl;

    assign disc     = ctrl[DISC_BIT-1];
    assign drive_ok = test_instr & disc & ctrl[DREN_BIT-1];
    assign lvl      = drive_lvl_e'(ctrl[LVL_LSB-1 +: LVL_W]);

    // Switch decode: core joined unless a test instruction disconnects it.
    always_comb begin
        sw      = '0;
        sw.core = ~(test_instr & disc);
        if (drive_ok) begin
            unique case (lvl)
                LVL_LOW:  sw.vl   = 1'b1;
                LVL_HIGH: sw.vh   = 1'b1;
                LVL_REF:  sw.vref = 1'b1;
                default:  ;
            endcase
        end
        sw.stim = test_instr & ctrl[STIM_BIT-1];
        sw.mon  = test_instr & ctrl[MON_BIT-1];
    end
endmodule

// File: rtl/abm_control_cell.sv
// Module: top of the analog pin control cell: serial stage, hold stage, decode.
// Assumes: the state strobes come from an external TAP controller on tck.
module abm_control_cell
    import abm_pkg::*;
(
    input  logic tck,
    input  logic rst_n,
    input  logic test_instr,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic update_dr,
    input  logic scan_in,
    input  logic comp_out,
    output logic scan_out,
    output logic sw_core,
    output logic sw_vh,
    output logic sw_vl,
    output logic sw_vref,
    output logic sw_bus_stim,
    output logic sw_bus_mon
);
    logic [CHAIN_LEN-1:1] stage_bits;
    logic [CTRL_W-1:0]    held;
    sw_en_t               sw;

    abm_shift_stage #(.LEN(CHAIN_LEN)) i_shift (
        .tck       (tck),
        .rst_n     (rst_n),
        .capture_en(capture_dr),
        .shift_en  (shift_dr),
        .scan_in   (scan_in),
        .sense_bit (comp_out),
        .held_bits (held),
        .scan_out  (scan_out),
        .par_out   (stage_bits)
    );

    abm_update_stage #(.W(CTRL_W)) i_hold (
        .tck    (tck),
        .rst_n  (rst_n),
        .load_en(update_dr),
        .d      (stage_bits),
        .q      (held)
    );

    abm_switch_decode i_dec (
        .test_instr(test_instr),
        .ctrl      (held),
        .sw        (sw)
    );

    assign sw_core     = sw.core;
    assign sw_vh       = sw.vh;
    assign sw_vl       = sw.vl;
    assign sw_vref     = sw.vref;
    assign sw_bus_stim = sw.stim;
    assign sw_bus_mon  = sw.mon;
endmodule

// File: rtl/abm_control_cell_sva.sv
// Module: property checker for the control cell, bound to the top.
// Assumes: it is connected only to the top-level ports.
module abm_control_cell_sva (
    input logic tck,
    input logic rst_n,
    input logic test_instr,
    input logic capture_dr,
    input logic update_dr,
    input logic comp_out,
    input logic scan_out,
    input logic sw_core,
    input logic sw_vh,
    input logic sw_vl,
    input logic sw_vref,
    input logic sw_bus_stim,
    input logic sw_bus_mon
);
    assert_reset_safe_R1: assert property (@(posedge tck)
        !rst_n |=> (sw_core && !sw_vh && !sw_vl && !sw_vref && !sw_bus_stim && !sw_bus_mon && !scan_out));

    assert_capture_sense_R2: assert property (@(posedge tck) disable iff (!rst_n)
        capture_dr |=> (scan_out == $past(comp_out)));

    assert_hold_stable_R4: assert property (@(posedge tck) disable iff (!rst_n)
        !update_dr |=> ($stable({sw_core, sw_vh, sw_vl, sw_vref, sw_bus_stim, sw_bus_mon})
                        || !$stable(test_instr)));

    assert_normal_mode_R5: assert property (@(posedge tck) disable iff (!rst_n)
        !test_instr |-> (sw_core && !sw_vh && !sw_vl && !sw_vref && !sw_bus_stim && !sw_bus_mon));

    assert_one_drive_R7: assert property (@(posedge tck) disable iff (!rst_n)
        $countones({sw_vh, sw_vl, sw_vref}) <= 1);

    assert_no_drive_on_core_R8: assert property (@(posedge tck) disable iff (!rst_n)
        (sw_vh || sw_vl || sw_vref) |-> !sw_core);
endmodule

bind abm_control_cell abm_control_cell_sva i_sva (
    .tck        (tck),
    .rst_n      (rst_n),
    .test_instr (test_instr),
    .capture_dr (capture_dr),
    .update_dr  (update_dr),
    .comp_out   (comp_out),
    .scan_out   (scan_out),
    .sw_core    (sw_core),
    .sw_vh      (sw_vh),
    .sw_vl      (sw_vl),
    .sw_vref    (sw_vref),
    .sw_bus_stim(sw_bus_stim),
    .sw_bus_mon (sw_bus_mon)
);

// File: tb/test_abm_control_cell.sv
// Bench: directed corners plus seeded random words. The expected switch
// enables are computed from the requirements.
module test_abm_control_cell;
    logic tck = 1'b0;
    logic rst_n, test_instr, capture_dr, shift_dr, update_dr, scan_in, comp_out;
    logic scan_out, sw_core, sw_vh, sw_vl, sw_vref, sw_bus_stim, sw_bus_mon;
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 0;

    always #5 tck = ~tck;

    abm_control_cell i_abm_control_cell (
        .tck(tck), .rst_n(rst_n), .test_instr(test_instr),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .scan_in(scan_in), .comp_out(comp_out), .scan_out(scan_out),
        .sw_core(sw_core), .sw_vh(sw_vh), .sw_vl(sw_vl), .sw_vref(sw_vref),
        .sw_bus_stim(sw_bus_stim), .sw_bus_mon(sw_bus_mon)
    );

    wire [5:0] sw_now = {sw_core, sw_vh, sw_vl, sw_vref, sw_bus_stim, sw_bus_mon};

    // Expected {core,vh,vl,vref,stim,mon} for an instruction gate and a held word w[6:1].
    function automatic [5:0] exp_sw(input bit it, input [6:1] w);
        bit drv;
        if (!it) return 6'b100000;
        drv = w[1] & w[2];
        return {~w[1], drv && w[4:3] == 2'd1, drv && w[4:3] == 2'd0,
                drv && w[4:3] == 2'd2, w[5], w[6]};
    endfunction

    task automatic check(input string req, input [6:0] act, input [6:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge tck);
        #1;
    endtask

    // Shift a word in (bit 0 first). got[] returns the bits seen on scan_out.
    // The switches are checked to stay at 'hold' during the shift (R4).
    task automatic shift_word(input [6:1] w, input [5:0] hold, output [6:0] got);
        logic [6:0] v;
        v = {w, 1'b0};
        for (int i = 0; i < 7; i++) begin
            got[i]   = scan_out;
            scan_in  = v[i];
            shift_dr = 1'b1;
            step();
            check("R4 switches stable during shift", {1'b0, sw_now}, {1'b0, hold});
        end
        shift_dr = 1'b0;
    endtask

    task automatic do_update();
        update_dr = 1'b1;
        step();
        update_dr = 1'b0;
    endtask

    task automatic do_capture(input bit c);
        comp_out   = c;
        capture_dr = 1'b1;
        step();
        capture_dr = 1'b0;
        check("R2 scan_out after capture", {6'd0, scan_out}, {6'd0, c});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [6:0] got;
        logic [6:1] held;
        logic [6:1] w;
        bit         c;
        void'($urandom(32'd1234));
        rst_n = 0; test_instr = 1; capture_dr = 0; shift_dr = 0; update_dr = 0;
        scan_in = 0; comp_out = 0;
        step(); step();
        // R1: reset state with the instruction active and inactive
        check("R1 reset switches (instr 1)", {scan_out, sw_now}, {1'b0, 6'b100000});
        test_instr = 0;
        #1;
        check("R1 reset switches (instr 0)", {scan_out, sw_now}, {1'b0, 6'b100000});
        rst_n = 1; test_instr = 1;
        held = '0;

        // R7: each level code with disconnect and drive enable set
        for (int l = 0; l < 4; l++) begin
            w = {1'b0, 1'b0, 2'(l), 1'b1, 1'b1};
            shift_word(w, exp_sw(1, held), got);
            do_update(); held = w;
            check("R7 level decode", {1'b0, sw_now}, {1'b0, exp_sw(1, held)});
            check("R6 core off when disconnected", {6'd0, sw_core}, 7'd0);
        end
        // R8: drive enabled but not disconnected
        w = 6'b001110;
        shift_word(w, exp_sw(1, held), got);
        do_update(); held = w;
        check("R8 no drive while core joined", {1'b0, sw_now}, {1'b0, 6'b100000});
        // R9: bus bits with the core joined, and R5 with the instruction low
        w = 6'b110000;
        shift_word(w, exp_sw(1, held), got);
        do_update(); held = w;
        check("R9 buses with core joined", {1'b0, sw_now}, {1'b0, 6'b100011});
        w = 6'b110111;
        shift_word(w, exp_sw(1, held), got);
        do_update(); held = w;
        test_instr = 0; #1;
        check("R5 normal mode overrides word", {1'b0, sw_now}, {1'b0, 6'b100000});
        test_instr = 1; #1;
        check("R6 word applies under instruction", {1'b0, sw_now}, {1'b0, exp_sw(1, held)});

        // R2/R3: capture, then read back while loading the next word
        do_capture(1'b1);
        shift_word(6'b000000, exp_sw(1, held), got);
        check("R3 readback of captured word", got, {held, 1'b1});
        // R10: capture and shift together; capture wins
        comp_out = 0; capture_dr = 1; shift_dr = 1; scan_in = 1;
        step();
        capture_dr = 0; shift_dr = 0;
        check("R10 capture over shift", {6'd0, scan_out}, 7'd0);
        // R4: an update with no shift reloads the same word
        do_update();
        check("R4 update reloads stage", {1'b0, sw_now}, {1'b0, exp_sw(1, held)});

        // Random words
        for (int k = 0; k < 60; k++) begin
            w = 6'($urandom);
            c = 1'($urandom);
            shift_word(w, exp_sw(test_instr, held), got);
            do_update(); held = w;
            test_instr = 1'($urandom); #1;
            check("R7 random decode", {1'b0, sw_now}, {1'b0, exp_sw(test_instr, held)});
            do_capture(c);
            shift_word(w, exp_sw(test_instr, held), got);
            check("R3 random readback", got, {held, c});
        end

        // R1: reset in the middle of a run
        test_instr = 1;
        w = 6'b011011;
        shift_word(w, exp_sw(1, held), got);
        do_update(); held = w;
        rst_n = 0;
        step();
        check("R1 mid-run reset", {scan_out, sw_now}, {1'b0, 6'b100000});
        rst_n = 1;
        finish_run();
    end
endmodule